// File: doc/BRIEF.md
# Early-Terminating Multiply-Accumulate Unit

This block is a sequential multiplier for 32-bit operands. It walks the multiplier operand one 8-bit digit per clock, starting at the least significant digit. After each digit it looks at the bits it has not yet used. If those bits are all zero, or all one where a sign-extended reading is allowed, it stops. A small multiplier therefore finishes in one cycle, and a full-width one takes at most four.

Four operation forms are selected by a 2-bit code:
- a truncated 32-bit product;
- a 32-bit product plus a 32-bit addend;
- a 64-bit product, signed or unsigned;
- a 64-bit product plus a 64-bit addend.

Operands enter through a valid/ready handshake. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low for the whole operation, and a request held or pulsed during that time is dropped, not queued.

The result side has no back-pressure. `out_valid` is high for one cycle. The result and its negative and zero flags then stay in their output registers until the next operation completes, so a consumer may capture them late.

Top module: `early_mac`

## Requirements
- R1: During and right after reset, `busy` and `out_valid` are 0 and `in_ready` is 1.
- R2: A request is accepted only on an edge with `in_valid` and `in_ready` both high. `in_ready` equals not `busy`. A request offered while busy has no effect on the result under way and starts no further operation.
- R3: With `in_op` = 2'b00, the result is the low 32 bits of `in_mcand` × `in_mplier`, and `in_signed` is ignored.
- R4: With `in_op` = 2'b01, the result is the low 32 bits of the product plus `in_acc[31:0]`.
- R5: With `in_op` = 2'b10, the result is the full 64-bit product. Both operands are read as two's complement when `in_signed` = 1 and as unsigned when it is 0.
- R6: With `in_op` = 2'b11, the result is the 64-bit product (signedness as in R5) plus `in_acc[63:0]`, taken modulo 2^64.
- R7: Iteration count is the smallest k in 1..4 for which multiplier bits [31:8k] are all zero. For every form except unsigned 64-bit, bits [31:8k] all being one also ends it. k = 4 always ends it.
- R8: From the accepting edge, `out_valid` rises after k + a + l further edges, where a = `in_op[0]` and l = `in_op[1]`. `busy` is high from the accepting edge until `out_valid` rises.
- R9: `out_valid` is high for exactly one cycle, and `out_result` does not change while `out_valid` is low.
- R10: `out_neg` is result bit 63 for the 64-bit forms and bit 31 for the 32-bit forms. `out_zero` is 1 exactly when the whole result is zero.
- R11: For the 32-bit forms, `out_result[63:32]` is zero, whatever `in_acc[63:32]` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Unit can take a request |
| in_op | input | 2 | Form: bit 0 adds the addend, bit 1 gives a 64-bit result |
| in_signed | input | 1 | Signed operands for the 64-bit forms |
| in_mcand | input | 32 | Multiplicand |
| in_mplier | input | 32 | Multiplier, consumed one digit per cycle |
| in_acc | input | 64 | Addend (low half only for the 32-bit form) |
| busy | output | 1 | Operation in progress |
| out_valid | output | 1 | One-cycle completion pulse |
| out_result | output | 64 | Result, held until the next completion |
| out_neg | output | 1 | Result sign flag |
| out_zero | output | 1 | Result zero flag |

## Verification
The multiplier values are chosen so that the measured latency separates the termination rules:
- short positive values that end after one or two digits;
- values whose upper bits are all ones, which end after one digit in the signed and 32-bit forms but run all four digits as unsigned 64-bit;
- a value with only the top bit set, which must run the full width.

Negative multiplicands combined with sign-extended early stops test the correction subtraction. Accumulating cases with addends that cancel the product exercise the zero flag, and an addend with a non-zero upper half checks that the 32-bit forms clear the high word. A request pulsed in mid-operation shows whether the busy-time input is really ignored.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ITER = 2'd1,
    ST_ADD  = 2'd2,
    ST_HIGH = 2'd3
  } mac_st_e;

endpackage

// File: rtl/mac_step.sv
// One radix-2^DW digit step: adds the shifted partial product and decides
// whether the unconsumed multiplier bits still carry information.
module mac_step #(
  parameter int XW = 32,
  parameter int DW = 8,
  localparam int PW   = 2 * XW,
  localparam int NDIG = XW / DW,
  localparam int PCW  = $clog2(NDIG + 1),
  localparam int SW   = $clog2(PW + 1)
) (
  input  logic [PW-1:0]  sum_q,
  input  logic [PW-1:0]  mcand_q,
  input  logic [XW-1:0]  rem_q,
  input  logic [PCW-1:0] pos_q,
  input  logic           sfill,
  output logic [PW-1:0]  sum_d,
  output logic [XW-1:0]  rem_d,
  output logic           stop
);

  logic [DW-1:0] digit;
  logic [DW-1:0] fill;
  logic [SW-1:0] sh_cur;
  logic [SW-1:0] sh_nxt;
  logic [PW-1:0] partial;
  logic [PW-1:0] corr;
  logic          rest_zero;
  logic          rest_ones;

  always_comb begin
    digit     = rem_q[DW-1:0];
    fill      = sfill ? {DW{rem_q[XW-1]}} : '0;
    rem_d     = {fill, rem_q[XW-1:DW]};
    rest_zero = ~|rem_d;
    rest_ones = sfill && (&rem_d);
    stop      = rest_zero || rest_ones;
    sh_cur    = SW'(pos_q) * SW'(DW);
    sh_nxt    = sh_cur + SW'(DW);
    partial   = (mcand_q * PW'(digit)) << sh_cur;
    // remaining bits read as -1: take one multiplicand weight off
    corr      = rest_ones ? (mcand_q << sh_nxt) : '0;
    sum_d     = sum_q + partial - corr;
  end

endmodule

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    in_valid,
  input  logic    op_add,
  input  logic    op_long,
  input  logic    step_stop,
  output logic    in_ready,
  output logic    busy,
  output logic    accept,
  output mac_st_e st,
  output logic    long_q,
  output logic    finish
);

  mac_st_e st_q, st_d;
  logic    add_q;

  assign st       = st_q;
  assign busy     = (st_q != ST_IDLE);
  assign in_ready = ~busy;
  assign accept   = in_valid && (st_q == ST_IDLE);

  always_comb begin
    st_d   = st_q;
    finish = 1'b0;
    unique case (st_q)
      ST_IDLE: if (accept) st_d = ST_ITER;
      ST_ITER: if (step_stop) begin
        if (add_q)       st_d = ST_ADD;
        else if (long_q) st_d = ST_HIGH;
        else begin
          st_d   = ST_IDLE;
          finish = 1'b1;
        end
      end
      ST_ADD: if (long_q) st_d = ST_HIGH;
        else begin
          st_d   = ST_IDLE;
          finish = 1'b1;
        end
      ST_HIGH: begin
        st_d   = ST_IDLE;
        finish = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      add_q  <= 1'b0;
      long_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        add_q  <= op_add;
        long_q <= op_long;
      end
    end
  end

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> busy); // R2

endmodule

// File: rtl/mac_flags.sv
module mac_flags #(
  parameter int XW = 32,
  localparam int PW = 2 * XW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          finish,
  input  logic          long_mode,
  input  logic [PW-1:0] fin_val,
  output logic          out_valid,
  output logic [PW-1:0] out_result,
  output logic          out_neg,
  output logic          out_zero
);

  logic [PW-1:0] res_d;

  always_comb begin
    res_d = long_mode ? fin_val : {{(PW-XW){1'b0}}, fin_val[XW-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_neg    <= 1'b0;
      out_zero   <= 1'b0;
    end else begin
      out_valid <= finish;
      if (finish) begin
        out_result <= res_d;
        out_neg    <= long_mode ? res_d[PW-1] : res_d[XW-1];
        out_zero   <= ~|res_d;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R9
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_result)); // R9
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_zero) |-> (out_result == '0)); // R10

endmodule

// File: rtl/early_mac.sv
module early_mac
  import mac_pkg::*;
#(
  parameter int XW = 32,
  parameter int DW = 8,
  localparam int PW   = 2 * XW,
  localparam int NDIG = XW / DW,
  localparam int PCW  = $clog2(NDIG + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_op,
  input  logic          in_signed,
  input  logic [XW-1:0] in_mcand,
  input  logic [XW-1:0] in_mplier,
  input  logic [PW-1:0] in_acc,
  output logic          busy,
  output logic          out_valid,
  output logic [PW-1:0] out_result,
  output logic          out_neg,
  output logic          out_zero
);

  mac_st_e        st;
  logic           accept;
  logic           finish;
  logic           long_q;
  logic           step_stop;
  logic [PW-1:0]  sum_q, sum_d;
  logic [PW-1:0]  mcand_q;
  logic [PW-1:0]  addend_q;
  logic [XW-1:0]  rem_q, rem_d;
  logic [PCW-1:0] pos_q;
  logic           sfill_q;
  logic [PW-1:0]  fin_val;
  logic           sign_ops;

  assign sign_ops = in_op[1] && in_signed;

  mac_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .op_add   (in_op[0]),
    .op_long  (in_op[1]),
    .step_stop(step_stop),
    .in_ready (in_ready),
    .busy     (busy),
    .accept   (accept),
    .st       (st),
    .long_q   (long_q),
    .finish   (finish)
  );

  mac_step #(.XW(XW), .DW(DW)) u_step (
    .sum_q  (sum_q),
    .mcand_q(mcand_q),
    .rem_q  (rem_q),
    .pos_q  (pos_q),
    .sfill  (sfill_q),
    .sum_d  (sum_d),
    .rem_d  (rem_d),
    .stop   (step_stop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q    <= '0;
      mcand_q  <= '0;
      addend_q <= '0;
      rem_q    <= '0;
      pos_q    <= '0;
      sfill_q  <= 1'b0;
    end else if (accept) begin
      sum_q    <= '0;
      mcand_q  <= sign_ops ? {{(PW-XW){in_mcand[XW-1]}}, in_mcand}
                           : {{(PW-XW){1'b0}}, in_mcand};
      addend_q <= in_op[1] ? in_acc : {{(PW-XW){1'b0}}, in_acc[XW-1:0]};
      rem_q    <= in_mplier;
      pos_q    <= '0;
      // sign-fill for every form except the unsigned 64-bit one
      sfill_q  <= !(in_op[1] && !in_signed);
    end else if (st == ST_ITER) begin
      sum_q <= sum_d;
      rem_q <= rem_d;
      pos_q <= pos_q + PCW'(1);
    end else if (st == ST_ADD) begin
      sum_q <= sum_q + addend_q;
    end
  end

  always_comb begin
    unique case (st)
      ST_ITER: fin_val = sum_d;
      ST_ADD:  fin_val = sum_q + addend_q;
      default: fin_val = sum_q;
    endcase
  end

  mac_flags #(.XW(XW)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .finish    (finish),
    .long_mode (long_q),
    .fin_val   (fin_val),
    .out_valid (out_valid),
    .out_result(out_result),
    .out_neg   (out_neg),
    .out_zero  (out_zero)
  );

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ITER && pos_q == PCW'(NDIG-1)) |-> step_stop); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !busy); // R8
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || out_valid)); // R8

endmodule

// File: tb/early_mac_tb_top.sv
`timescale 1ns/1ps
module early_mac_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_op = 2'b00;
  logic        in_signed = 1'b0;
  logic [31:0] in_mcand = '0;
  logic [31:0] in_mplier = '0;
  logic [63:0] in_acc = '0;
  logic        busy;
  logic        out_valid;
  logic [63:0] out_result;
  logic        out_neg;
  logic        out_zero;

  int errors = 0;
  int checks = 0;
  bit done_run = 1'b0;

  always #2 clk = ~clk;

  early_mac dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_signed(in_signed), .in_mcand(in_mcand),
    .in_mplier(in_mplier), .in_acc(in_acc), .busy(busy),
    .out_valid(out_valid), .out_result(out_result), .out_neg(out_neg),
    .out_zero(out_zero)
  );

  // {op[1:0], signed, mcand[31:0], mplier[31:0], acc[63:0]}
  localparam int NV = 13;
  localparam logic [130:0] VECS [NV] = '{
    {2'b00, 1'b0, 32'h0000_0007, 32'h0000_0005, 64'h0},
    {2'b00, 1'b1, 32'h1234_5678, 32'h9ABC_DEF0, 64'h0},
    {2'b00, 1'b0, 32'h0000_0003, 32'hFFFF_FFFF, 64'h0},
    {2'b01, 1'b0, 32'h0000_1000, 32'h0000_0100, 64'hFFFF_FFFF_0000_0005},
    {2'b01, 1'b0, 32'h0000_0001, 32'hFFFF_FFFF, 64'h0000_0000_0000_0001},
    {2'b10, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'h0},
    {2'b10, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'h0},
    {2'b10, 1'b1, 32'h7FFF_FFFF, 32'hFFFF_FF80, 64'h0},
    {2'b10, 1'b0, 32'h0000_0010, 32'h00FF_0000, 64'h0},
    {2'b11, 1'b1, 32'h8000_0000, 32'h0000_0002, 64'h0000_0001_0000_0000},
    {2'b11, 1'b0, 32'h1234_5678, 32'h00AB_CDEF, 64'h1111_1111_2222_2222},
    {2'b00, 1'b0, 32'h0000_0000, 32'h0080_0000, 64'h0},
    {2'b10, 1'b1, 32'h0000_0003, 32'h8000_0000, 64'h0}
  };

  function automatic logic [63:0] model_res(logic [1:0] op, logic sg,
      logic [31:0] a, logic [31:0] b, logic [63:0] acc);
    logic [63:0] ae, be, p;
    if (op[1]) begin
      ae = sg ? {{32{a[31]}}, a} : {32'h0, a};
      be = sg ? {{32{b[31]}}, b} : {32'h0, b};
      p  = ae * be;
      if (op[0]) p = p + acc;
      return p;
    end
    p = {32'h0, a} * {32'h0, b};
    if (op[0]) p = p + {32'h0, acc[31:0]};
    return {32'h0, p[31:0]};
  endfunction

  function automatic int model_iters(logic [1:0] op, logic sg, logic [31:0] b);
    bit ones_ok = !(op[1] && !sg);
    for (int k = 1; k <= 4; k++) begin
      bit z = 1'b1;
      bit o = 1'b1;
      for (int j = 8 * k; j < 32; j++) begin
        if (b[j]) z = 1'b0; else o = 1'b0;
      end
      if (z || (ones_ok && o)) return k;
    end
    return 4;
  endfunction

  function automatic string req_of(logic [1:0] op);
    case (op)
      2'b00:   return "R3";
      2'b01:   return "R4";
      2'b10:   return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done_run) begin
      done_run = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // drive at a negedge, accept at next posedge; returns at negedge after accept
  task automatic offer(logic [1:0] op, logic sg, logic [31:0] a, logic [31:0] b, logic [63:0] acc);
    in_op = op; in_signed = sg; in_mcand = a; in_mplier = b; in_acc = acc;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!out_valid && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic run_vec(logic [1:0] op, logic sg, logic [31:0] a, logic [31:0] b, logic [63:0] acc);
    int cyc;
    int exp_cyc;
    logic [63:0] er;
    er = model_res(op, sg, a, b, acc);
    exp_cyc = model_iters(op, sg, b) + int'(op[0]) + int'(op[1]);
    offer(op, sg, a, b, acc);
    wait_done(cyc);
    check(out_result == er, req_of(op), "result", out_result, er);
    check(cyc == exp_cyc, "R7/R8", "latency", 64'(cyc), 64'(exp_cyc));
    check(out_neg == (op[1] ? er[63] : er[31]), "R10", "neg flag", 64'(out_neg), 64'(op[1] ? er[63] : er[31]));
    check(out_zero == (er == 64'h0), "R10", "zero flag", 64'(out_zero), 64'(er == 64'h0));
    if (!op[1]) check(out_result[63:32] == 32'h0, "R11", "upper word", 64'(out_result[63:32]), 64'h0);
    check(in_ready == 1'b1, "R2", "ready at done", 64'(in_ready), 64'h1);
    @(negedge clk);
    check(out_valid == 1'b0, "R9", "pulse width", 64'(out_valid), 64'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    summary();
  end

  initial begin
    int cyc;
    logic [63:0] keep;
    logic [63:0] er;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy == 1'b0 && out_valid == 1'b0 && in_ready == 1'b1, "R1", "reset outputs",
          {61'h0, busy, out_valid, in_ready}, 64'h1);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && out_valid == 1'b0 && in_ready == 1'b1, "R1", "after reset",
          {61'h0, busy, out_valid, in_ready}, 64'h1);

    for (int i = 0; i < NV; i++) begin
      run_vec(VECS[i][130:129], VECS[i][128], VECS[i][127:96], VECS[i][95:64], VECS[i][63:0]);
    end

    // R3: in_signed has no effect on the 32-bit product
    run_vec(2'b00, 1'b1, 32'hFFFF_FFF0, 32'h0000_0013, 64'h0);

    // R2: request offered while busy is ignored
    er = model_res(2'b11, 1'b1, 32'hDEAD_BEEF, 32'h1234_5678, 64'h0000_0000_0000_00FF);
    offer(2'b11, 1'b1, 32'hDEAD_BEEF, 32'h1234_5678, 64'h0000_0000_0000_00FF);
    check(in_ready == 1'b0 && busy == 1'b1, "R2", "ready low while busy",
          {62'h0, in_ready, busy}, 64'h1);
    offer(2'b00, 1'b0, 32'h0000_0002, 32'h0000_0002, 64'h0);
    wait_done(cyc);
    check(cyc == 5, "R8", "latency with stray request", 64'(cyc), 64'd5);
    check(out_result == er, "R2", "result unaffected", out_result, er);
    keep = out_result;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check(out_valid == 1'b0 && busy == 1'b0, "R2", "no second operation",
            {62'h0, out_valid, busy}, 64'h0);
    end
    check(out_result == keep, "R9", "result held", out_result, keep);

    summary();
  end

endmodule